// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block sits between a processor's load/store port and a data bus that only carries naturally aligned transfers. The processor side presents an address, an access size (byte, halfword or word), a write flag and write data. When the request is aligned to its size, the block issues it to the bus as one transfer. When it is not aligned, the block issues a fixed, case-specific sequence of aligned sub-transfers. For writes it shifts each part of the data onto the correct byte lanes. For reads it gathers each returned part into place. It then reports one completion with the assembled read data.

The split depends on the size and on the low address bits:
- An odd halfword becomes two bytes.
- A word at offset 2 becomes two halfwords.
- A word at offset 1 or 3 becomes byte, halfword, byte.

Sub-transfers run in ascending address order. Each one waits for the bus ready before the next is issued. Byte order is little-endian.

Top module: `unaligned_splitter`

## Requirements
- R1: A request aligned to its size (every byte; halfword with A[0]=0; word with A[1:0]=00) is issued as exactly one bus transfer with the same address and size.
- R2: A halfword request with A[0]=1 is issued as two byte transfers, at A and then A+1.
- R3: A word request with A[1:0]=10 is issued as two halfword transfers, at A and then A+2.
- R4: A word request with A[1:0]=01 or 11 is issued as three transfers: byte at A, halfword at A+1, byte at A+3.
- R5: Every bus transfer is naturally aligned to its bus size, encoded 0=byte, 1=halfword, 2=word. Its 4-bit byte enable is 1, 2 or 4 contiguous ones (for those sizes) shifted left by the bus address bits [1:0].
- R6: A bus transfer holds its address, size, enables and data unchanged while bus ready is low. Consecutive transfers of one request step upward by 1 or 2 bytes.
- R7: On writes, byte k of the write data (bits 8k+7:8k) reaches address A+k on the enabled lane. No byte outside A to A+size-1 is written.
- R8: On reads, the byte at A+k is returned in bits 8k+7:8k of the read data. Bytes beyond the access size read as zero.
- R9: Completion is a one-cycle pulse in the cycle after the last bus handshake. No bus transfer is active during that pulse. A new request is taken only when the block is idle.
- R10: After reset, no bus transfer is requested and no completion is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request valid; held until cpu_ready |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 32 | Write data, least significant byte at lowest address |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Assembled read data, valid with cpu_ready |
| bus_req | output | 1 | Bus transfer valid |
| bus_addr | output | ADDR_W | Aligned transfer address |
| bus_size | output | 2 | Transfer size, 0/1/2 |
| bus_we | output | 1 | Transfer is a write |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Lane-placed write data |
| bus_ready | input | 1 | Transfer completes at this edge |
| bus_rdata | input | 32 | Word-lane read data |

## Verification
Assertions check several rules on every cycle: that each bus transfer is aligned with a byte-enable pattern matching its size, that a stalled transfer holds still, that successive pieces climb by one or two bytes, and that completion is a single pulse with the bus quiet. Only the bench's scenarios can show the rest. That covers the exact piece sequence for each size and offset, that write data lands on the right bytes and nowhere else, that read data is assembled little-endian with zero upper bytes, and that completion comes exactly one cycle after the final handshake. The bench sweeps every size over eight consecutive addresses, for both reads and writes, against a bus model with varying wait states.

// File: rtl/unaligned_splitter.sv
module unaligned_splitter #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_we,
  output logic [3:0]        bus_be,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ready,
  input  logic [31:0]       bus_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] r_addr;
  logic [1:0]        r_size;
  logic              r_we;
  logic [31:0]       r_wdata;
  logic [1:0]        idx;
  logic [31:0]       acc;

  logic [1:0]  off, rel, psize, npieces, lane;
  logic [3:0]  smask;
  logic [31:0] lmask, rd_piece;
  logic [4:0]  rel_sh, lane_sh;
  logic        last;

  assign off = r_addr[1:0];

  always_comb begin
    npieces = 2'd1;
    if (r_size == 2'd1 && off[0])
      npieces = 2'd2;
    else if (r_size[1] && off == 2'd2)
      npieces = 2'd2;
    else if (r_size[1] && off[0])
      npieces = 2'd3;
  end

  always_comb begin
    rel   = 2'd0;
    psize = r_size[1] ? 2'd2 : r_size;
    if (r_size == 2'd1 && off[0]) begin
      psize = 2'd0;
      rel   = {1'b0, idx[0]};
    end else if (r_size[1] && off == 2'd2) begin
      psize = 2'd1;
      rel   = idx[0] ? 2'd2 : 2'd0;
    end else if (r_size[1] && off[0]) begin
      case (idx)
        2'd0:    begin psize = 2'd0; rel = 2'd0; end
        2'd1:    begin psize = 2'd1; rel = 2'd1; end
        default: begin psize = 2'd0; rel = 2'd3; end
      endcase
    end
  end

  assign last     = (idx == npieces - 2'd1);
  assign bus_addr = r_addr + ADDR_W'(rel);
  assign lane     = bus_addr[1:0];
  assign rel_sh   = {rel, 3'b000};
  assign lane_sh  = {lane, 3'b000};
  assign smask    = (psize == 2'd0) ? 4'b0001 : (psize == 2'd1) ? 4'b0011 : 4'b1111;
  assign lmask    = {{8{smask[3]}}, {8{smask[2]}}, {8{smask[1]}}, {8{smask[0]}}};
  assign rd_piece = (bus_rdata >> lane_sh) & lmask;

  assign bus_req   = (state == S_BUS);
  assign bus_size  = psize;
  assign bus_we    = r_we;
  assign bus_be    = smask << lane;
  assign bus_wdata = ((r_wdata >> rel_sh) & lmask) << lane_sh;
  assign cpu_ready = (state == S_DONE);
  assign cpu_rdata = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      r_addr  <= '0;
      r_size  <= 2'd0;
      r_we    <= 1'b0;
      r_wdata <= '0;
      idx     <= 2'd0;
      acc     <= '0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req) begin
          r_addr  <= cpu_addr;
          r_size  <= cpu_size;
          r_we    <= cpu_we;
          r_wdata <= cpu_wdata;
          idx     <= 2'd0;
          acc     <= '0;
          state   <= S_BUS;
        end
        S_BUS: if (bus_ready) begin
          if (!r_we) acc <= acc | (rd_piece << rel_sh);
          if (last) state <= S_DONE;
          else      idx   <= idx + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_size == 2'd0) || (bus_size == 2'd1 && !bus_addr[0]) ||
                (bus_size == 2'd2 && bus_addr[1:0] == 2'b00));

  assert_be_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones(bus_be) == (32'd1 << bus_size)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_be) &&
                              $stable(bus_size) && $stable(bus_wdata));

  assert_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ready |=> !bus_req ||
      ((bus_addr - $past(bus_addr)) == ADDR_W'(1)) ||
      ((bus_addr - $past(bus_addr)) == ADDR_W'(2)));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req ##1 !cpu_ready);

endmodule

// File: tb/unaligned_splitter_bench.sv
module unaligned_splitter_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_req = 0;
  logic [31:0] cpu_addr = 0;
  logic [1:0]  cpu_size = 0;
  logic        cpu_we = 0;
  logic [31:0] cpu_wdata = 0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_we;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_ready = 0;
  logic [31:0] bus_rdata = 0;

  unaligned_splitter #(.ADDR_W(32)) u_unaligned_splitter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, last_hs = 0;
  logic [7:0]  mem [256];
  logic [7:0]  refm[256];
  logic [31:0] la [4];
  logic [1:0]  ls [4];
  logic [3:0]  lb [4];
  int ln = 0, wsel = 0, waitn = 0;
  bit busy_piece = 0;
  logic [31:0] hold_a;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_req) begin
      if (!busy_piece) begin
        busy_piece = 1; hold_a = bus_addr; waitn = wsel % 3; wsel++;
      end else
        chk(bus_addr == hold_a, "R6 held address", bus_addr, hold_a);
      if (waitn == 0) begin
        for (int k = 0; k < 4; k++) begin
          bus_rdata[8*k +: 8] = mem[{bus_addr[7:2], 2'(k)}];
          if (bus_we && bus_be[k]) mem[{bus_addr[7:2], 2'(k)}] = bus_wdata[8*k +: 8];
        end
        if (ln < 4) begin la[ln] = bus_addr; ls[ln] = bus_size; lb[ln] = bus_be; end
        ln++;
        bus_ready = 1; last_hs = cyc; busy_piece = 0;
      end else begin
        waitn--; bus_ready = 0;
      end
    end else begin
      bus_ready = 0; busy_piece = 0;
    end
  end

  task automatic txn(input logic [31:0] a, input logic [1:0] sz, input bit we, input logic [31:0] wd);
    int nb, p, r, k, es, guard;
    logic [31:0] got, exp;
    string tag;
    nb = 1 << sz;
    if (sz == 0 || (a % nb) == 0) tag = "R1";
    else if (sz == 1) tag = "R2";
    else if (a[1:0] == 2'b10) tag = "R3";
    else tag = "R4";
    @(negedge clk);
    ln = 0;
    cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd; cpu_req = 1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!cpu_ready && guard < 100);
    got = cpu_rdata;
    chk(cpu_ready && cyc == last_hs + 1, "R9 completion timing", cyc, last_hs + 1);
    cpu_req = 0;
    @(negedge clk);
    chk(!cpu_ready, "R9 single pulse", {31'd0, cpu_ready}, 0);
    p = a; r = nb; k = 0;
    while (r > 0) begin
      if (p % 4 == 0 && r >= 4) es = 2;
      else if (p % 2 == 0 && r >= 2) es = 1;
      else es = 0;
      if (k < 4) begin
        chk(la[k] == p && ls[k] == 2'(es), tag, {la[k][29:0], ls[k]}, {p[29:0], 2'(es)});
        chk(lb[k] == 4'(((1 << (1 << es)) - 1) << (p % 4)), "R5 byte enable", {28'd0, lb[k]},
            ((1 << (1 << es)) - 1) << (p % 4));
      end
      p += (1 << es); r -= (1 << es); k++;
    end
    chk(ln == k, tag, ln, k);
    if (we) begin
      bit same = 1;
      for (int i = 0; i < nb; i++) refm[a + i] = wd[8*i +: 8];
      for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) same = 0;
      chk(same, "R7 memory image", {31'd0, same}, 1);
    end else begin
      exp = 0;
      for (int i = 0; i < nb; i++) exp[8*i +: 8] = refm[a + i];
      chk(got == exp, "R8 read data", got, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; refm[i] = 8'(i) ^ 8'h5A; end
    repeat (3) @(negedge clk);
    chk(!bus_req && !cpu_ready, "R10 reset outputs", {30'd0, bus_req, cpu_ready}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!bus_req && !cpu_ready, "R10 idle after reset", {30'd0, bus_req, cpu_ready}, 0);
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 8; o++) begin
        txn(32'h40 + 32'(o) + 32'(s * 16), 2'(s), 1, 32'hA1B2C3D4 ^ (32'(o * 7 + s) * 32'h01010101));
        txn(32'h40 + 32'(o) + 32'(s * 16), 2'(s), 0, 32'hFFFF_FFFF);
      end
    for (int o = 0; o < 4; o++) txn(32'h80 + 32'(o), 2'd2, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule